// File: doc/BRIEF.md
# MSI capture ring controller

This block receives message-signalled interrupt writes and stores each one as a 16-byte record in a circular buffer that lives in system memory. For every captured message it issues a single wide write request through a simple request/acknowledge memory port. The record's first 32-bit word, stored little-endian, carries the low 16 bits of the message data. The remaining twelve bytes of the record are zero.

Software sets up the block through a small word-addressed register port. Through it, software programs the 64-bit buffer base, picks one of four power-of-two buffer sizes and sets the enable bits. It then drains records by moving the consumer (read) offset forward. The producer (write) offset is owned by hardware and only advances once the memory port has taken the record. A single interrupt line stays high while unread records remain. When the ring is full, the block does one of two things: it drops the new message and records a sticky status bit, or it overwrites the oldest record.

Top module: `msi_ring_capture`

## Requirements
- R1: After reset, the control, base-high, base-low, read-offset and write-offset registers all read as zero. irqOut and memReq are low, and msiReady is high.
- R2: The register word addresses are as follows. Address 0 is control, 3 is base high, 4 is base low, 5 is the read offset and 6 is the write offset. Address 6 is read-only: a write to it has no effect. Every other address reads as zero. The control bits are: bit 0 block enable, bit 1 full-status enable, bit 3 interrupt enable, bit 4 stop-on-full, bits 9:8 size code, and bit 16 sticky full status.
- R3: The size code c selects a ring of 2^(15+c) bytes. Each offset is reported ANDed with the size mask, which is (size-1) with bits 3:0 cleared.
- R4: Each message accepted while enabled (msiValid and msiReady high at a clock edge) raises memReq on the next cycle. The request carries memAddr = {base high, base low} + write offset. It also carries memData, whose bits 15:0 equal msiData[15:0] and whose bits 127:16 are zero. The request stays high until memAck, and msiReady is low for as long as it is pending.
- R5: The write offset advances by 16 modulo the ring size, and only in the cycle in which memAck meets memReq. It wraps from size-16 to zero.
- R6: A value written to the read offset is stored ANDed with the current size mask.
- R7: While control bit 0 is clear, messages are accepted and discarded. No memory request is made and the offsets do not change.
- R8: The ring is full when (write offset + 16) masked equals the read offset. Under that condition, with stop-on-full set, a message is discarded. The sticky bit 16 is then set if bit 1 is set. Writing control with bit 16 set clears the sticky bit.
- R9: The ring can also be full with stop-on-full clear. In that case the record is still written, and when it is acknowledged the read offset also advances by 16 modulo the size.
- R10: irqOut is high exactly when control bits 0 and 3 are both set and the masked read offset differs from the masked write offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| msiValid | input | 1 | Inbound message present |
| msiData | input | 32 | Inbound message data word |
| msiReady | output | 1 | Block can take a message this cycle |
| memReq | output | 1 | Record write request |
| memAddr | output | 64 | Record byte address |
| memData | output | 128 | Record contents, byte k in bits 8k+7:8k |
| memAck | input | 1 | Memory port accepts the request |
| irqOut | output | 1 | Unread-records interrupt |

## Verification
The assertions rely on a few properties of the block's surroundings. The memory port is assumed to acknowledge only while a request is high. The size code is assumed to stay fixed while a record is in flight. Software is assumed not to move the read offset in the same cycle as an acknowledgement that overwrites the oldest record. The stimulus respects all three: the bench acknowledgement is gated by memReq, control is rewritten only after the ring is idle, and read-offset writes are issued only when no request is pending. Messages are offered only in a cycle that follows a low-to-high check of msiReady, so every handshake lands on a known edge.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL    = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_BASE_HI = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_BASE_LO = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_RD_OFF  = 3'd5;
  localparam logic [REG_ADDR_W-1:0] ADDR_WR_OFF  = 3'd6;

  localparam int BIT_EN       = 0;
  localparam int BIT_FULL_IND = 1;
  localparam int BIT_IRQ_EN   = 3;
  localparam int BIT_STOP     = 4;
  localparam int BIT_SIZE_LO  = 8;
  localparam int BIT_STICKY   = 16;

  typedef struct packed {
    logic captureLoad;
    logic ackDone;
    logic dropFull;
  } ringStrobe_t;

endpackage

// File: rtl/msi_ring_ctrl_fsm.sv
module msi_ring_ctrl_fsm
  import msi_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        msiValid,
  input  logic        memAck,
  input  logic        ctlEn,
  input  logic        ctlStop,
  input  logic        ringFull,
  output logic        msiReady,
  output logic        memReq,
  output ringStrobe_t strobe
);

  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} ctlState_t;

  ctlState_t state;
  ctlState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (msiValid && ctlEn) begin
          if (ringFull && ctlStop) begin
            strobe.dropFull = 1'b1;
          end else begin
            strobe.captureLoad = 1'b1;
            stateNext = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (memAck) begin
          strobe.ackDone = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign msiReady = (state == ST_IDLE);
  assign memReq   = (state == ST_BUSY);

  // R4: a pending record stays requested until the port takes it
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R8: a message met by a full ring in stop mode makes no request
  assert_drop_no_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (msiValid && msiReady && ctlEn && ringFull && ctlStop) |=> !memReq);

  // R7: with the block disabled a message makes no request
  assert_off_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msiValid && msiReady && !ctlEn) |=> !memReq);

endmodule

// File: rtl/msi_ring_dpath.sv
module msi_ring_dpath
  import msi_ring_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MSG_W     = 16,
  parameter int REC_BYTES = 16,
  parameter int MIN_SHIFT = 15,
  parameter int CODE_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWe,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [DATA_W-1:0]     msiData,
  input  ringStrobe_t           strobe,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [REC_BYTES*8-1:0] memData,
  output logic                  irqOut,
  output logic                  ctlEn,
  output logic                  ctlStop,
  output logic                  ringFull
);

  localparam int ADDR_W    = 2 * DATA_W;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int OFF_W     = MIN_SHIFT + (1 << CODE_W) - 1;
  localparam int REC_SHIFT = $clog2(REC_BYTES);

  logic              enBit, fullIndBit, irqEnBit, stopBit, stickyFull;
  logic [CODE_W-1:0] sizeCode;
  logic [DATA_W-1:0] baseHi, baseLo;
  logic [OFF_W-1:0]  rdOff, wrOff;
  logic [MSG_W-1:0]  recData;

  logic [OFF_W:0]    spanBytes;
  logic [OFF_W-1:0]  sizeMask, rdM, wrM, wrNext, rdNext;
  logic              ctrlWrite, rdWrite, ackDone, dropFull;

  always_comb begin
    spanBytes = (OFF_W+1)'(1) << (MIN_SHIFT + int'(sizeCode));
    sizeMask  = (spanBytes[OFF_W-1:0] - OFF_W'(1)) & ~OFF_W'(REC_BYTES - 1);
  end

  assign rdM       = rdOff & sizeMask;
  assign wrM       = wrOff & sizeMask;
  assign wrNext    = (wrM + OFF_W'(REC_BYTES)) & sizeMask;
  assign rdNext    = (rdM + OFF_W'(REC_BYTES)) & sizeMask;
  assign ringFull  = (wrNext == rdM);
  assign ctrlWrite = regWe && (regAddr == ADDR_CTRL);
  assign rdWrite   = regWe && (regAddr == ADDR_RD_OFF);
  assign ackDone   = strobe.ackDone;
  assign dropFull  = strobe.dropFull;

  // control register and sticky status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit      <= 1'b0;
      fullIndBit <= 1'b0;
      irqEnBit   <= 1'b0;
      stopBit    <= 1'b0;
      sizeCode   <= '0;
      stickyFull <= 1'b0;
    end else begin
      if (ctrlWrite) begin
        enBit      <= regWdata[BIT_EN];
        fullIndBit <= regWdata[BIT_FULL_IND];
        irqEnBit   <= regWdata[BIT_IRQ_EN];
        stopBit    <= regWdata[BIT_STOP];
        sizeCode   <= regWdata[BIT_SIZE_LO +: CODE_W];
      end
      if (dropFull && fullIndBit) stickyFull <= 1'b1;
      else if (ctrlWrite && regWdata[BIT_STICKY]) stickyFull <= 1'b0;
    end
  end

  // base address pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi <= '0;
      baseLo <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_BASE_HI) baseHi <= regWdata;
      if (regAddr == ADDR_BASE_LO) baseLo <= regWdata;
    end
  end

  // offsets: software owns the consumer side, hardware the producer side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOff <= '0;
      wrOff <= '0;
    end else begin
      if (rdWrite)                  rdOff <= regWdata[OFF_W-1:0] & sizeMask;
      else if (ackDone && ringFull) rdOff <= rdNext;
      if (ackDone)                  wrOff <= wrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   recData <= '0;
    else if (strobe.captureLoad) recData <= msiData[MSG_W-1:0];
  end

  assign memAddr = {baseHi, baseLo} + ADDR_W'(wrM);
  assign memData = {{(REC_W-MSG_W){1'b0}}, recData};
  assign irqOut  = enBit && irqEnBit && (rdM != wrM);
  assign ctlEn   = enBit;
  assign ctlStop = stopBit;

  logic [DATA_W-1:0] ctrlWord;
  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_EN]                  = enBit;
    ctrlWord[BIT_FULL_IND]            = fullIndBit;
    ctrlWord[BIT_IRQ_EN]              = irqEnBit;
    ctrlWord[BIT_STOP]                = stopBit;
    ctrlWord[BIT_SIZE_LO +: CODE_W]   = sizeCode;
    ctrlWord[BIT_STICKY]              = stickyFull;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:    regRdata = ctrlWord;
      ADDR_BASE_HI: regRdata = baseHi;
      ADDR_BASE_LO: regRdata = baseLo;
      ADDR_RD_OFF:  regRdata = DATA_W'(rdM);
      ADDR_WR_OFF:  regRdata = DATA_W'(wrM);
      default:      regRdata = '0;
    endcase
  end

  // R5: an acknowledged record moves the producer exactly one slot
  assert_wr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ackDone) && !$past(ctrlWrite)) |->
      (wrM == (($past(wrM) + OFF_W'(REC_BYTES)) & sizeMask)));

  // R8: the sticky bit only rises after a dropped message
  assert_sticky_src_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyFull) |-> $past(dropFull));

  // R10: the interrupt only rises after an acknowledgement or a register write
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(ackDone || regWe));

endmodule

// File: rtl/msi_ring_capture.sv
module msi_ring_capture
  import msi_ring_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MSG_W     = 16,
  parameter int REC_BYTES = 16,
  parameter int MIN_SHIFT = 15,
  parameter int CODE_W    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [REG_ADDR_W-1:0]  regAddr,
  input  logic                   regWe,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  input  logic                   msiValid,
  input  logic [DATA_W-1:0]      msiData,
  output logic                   msiReady,
  output logic                   memReq,
  output logic [2*DATA_W-1:0]    memAddr,
  output logic [REC_BYTES*8-1:0] memData,
  input  logic                   memAck,
  output logic                   irqOut
);

  ringStrobe_t strobe;
  logic        ctlEn, ctlStop, ringFull;

  msi_ring_ctrl_fsm ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .msiValid (msiValid),
    .memAck   (memAck),
    .ctlEn    (ctlEn),
    .ctlStop  (ctlStop),
    .ringFull (ringFull),
    .msiReady (msiReady),
    .memReq   (memReq),
    .strobe   (strobe)
  );

  msi_ring_dpath #(
    .DATA_W    (DATA_W),
    .MSG_W     (MSG_W),
    .REC_BYTES (REC_BYTES),
    .MIN_SHIFT (MIN_SHIFT),
    .CODE_W    (CODE_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .msiData  (msiData),
    .strobe   (strobe),
    .memAddr  (memAddr),
    .memData  (memData),
    .irqOut   (irqOut),
    .ctlEn    (ctlEn),
    .ctlStop  (ctlStop),
    .ringFull (ringFull)
  );

endmodule

// File: tb/msi_ring_capture_tb_top.sv
`timescale 1ns/1ps
module msi_ring_capture_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   regAddr = '0;
  logic         regWe = 1'b0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic         msiValid = 1'b0;
  logic [31:0]  msiData = '0;
  logic         msiReady;
  logic         memReq;
  logic [63:0]  memAddr;
  logic [127:0] memData;
  logic         memAck = 1'b0;
  logic         irqOut;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit ackStall = 1'b0;
  int ackPhase = 0;

  always #4 clk = ~clk;

  msi_ring_capture dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .msiValid(msiValid),
    .msiData(msiData), .msiReady(msiReady), .memReq(memReq),
    .memAddr(memAddr), .memData(memData), .memAck(memAck), .irqOut(irqOut)
  );

  // ---------------- behavioural reference ----------------
  int mEn = 0, mFi = 0, mIrqEn = 0, mStop = 0, mCode = 0, mSticky = 0;
  int unsigned mHi = 0, mLo = 0;
  int mRd = 0, mWr = 0, mData = 0;
  bit mBusy = 1'b0;

  function automatic int maskOf(int code);
    return ((1 << (15 + code)) - 1) & ~15;
  endfunction

  function automatic int unsigned expRead(int addr);
    int m;
    m = maskOf(mCode);
    case (addr)
      0: return (mSticky << 16) | (mCode << 8) | (mStop << 4) | (mIrqEn << 3) | (mFi << 1) | mEn;
      3: return mHi;
      4: return mLo;
      5: return mRd & m;
      6: return mWr & m;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int m, rdm, wrm, nx, nRd, nWr, nSticky;
    bit full, nBusy;
    if (!rstN) begin
      mEn = 0; mFi = 0; mIrqEn = 0; mStop = 0; mCode = 0; mSticky = 0;
      mHi = 0; mLo = 0; mRd = 0; mWr = 0; mData = 0; mBusy = 0;
    end else begin
      m = maskOf(mCode);
      rdm = mRd & m; wrm = mWr & m;
      nx = (wrm + 16) & m;
      full = (nx == rdm);
      nRd = mRd; nWr = mWr; nBusy = mBusy; nSticky = mSticky;
      if (mBusy && memAck) begin
        nWr = nx;
        if (full) nRd = (rdm + 16) & m;
        nBusy = 0;
      end
      if (!mBusy && msiValid && mEn != 0) begin
        if (full && mStop != 0) begin
          if (mFi != 0) nSticky = 2;
        end else begin
          nBusy = 1;
          mData = msiData & 32'hFFFF;
        end
      end
      if (regWe) begin
        case (regAddr)
          3'd0: begin
            mEn = regWdata[0]; mFi = regWdata[1]; mIrqEn = regWdata[3];
            mStop = regWdata[4]; mCode = regWdata[9:8];
            if (regWdata[16] && nSticky != 2) nSticky = 0;
          end
          3'd3: mHi = regWdata;
          3'd4: mLo = regWdata;
          3'd5: nRd = regWdata & m;
          default: ;
        endcase
      end
      mRd = nRd; mWr = nWr; mBusy = nBusy;
      mSticky = (nSticky != 0) ? 1 : 0;
    end
  end

  task automatic check64(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    int m;
    if (live) begin
      m = maskOf(mCode);
      check64(memReq == mBusy, "R4 memReq", memReq, mBusy);
      check64(msiReady == !mBusy, "R4 msiReady", msiReady, !mBusy);
      check64(irqOut == (mEn != 0 && mIrqEn != 0 && (mRd & m) != (mWr & m)),
              "R10 irqOut", irqOut, (mEn != 0 && mIrqEn != 0 && (mRd & m) != (mWr & m)));
      check64(regRdata == expRead(regAddr), "R2 regRdata", regRdata, expRead(regAddr));
      if (mBusy) begin
        check64(memAddr == ({mHi, mLo} + 64'(mWr & m)), "R4 memAddr", memAddr, {mHi, mLo} + 64'(mWr & m));
        check64(memData == 128'(mData), "R4 memData", memData, 128'(mData));
      end
    end
  end

  // memory port: acknowledges with varying latency
  always @(negedge clk) begin
    #1;
    ackPhase++;
    memAck = memReq && !ackStall && (ackPhase % 3 != 1);
  end

  // ---------------- stimulus ----------------
  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic regCheck(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    regAddr = a;
    @(negedge clk);
    check64(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic sendMsi(logic [31:0] d);
    forever begin
      @(negedge clk);
      if (msiReady) break;
    end
    #1; msiValid = 1'b1; msiData = d;
    @(negedge clk); #1;
    msiValid = 1'b0;
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (!memReq) break;
    end
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1'b1;
        live = 1'b1;
        @(negedge clk);
        // R1 reset state
        check64(irqOut == 0, "R1 irqOut", irqOut, 0);
        check64(memReq == 0, "R1 memReq", memReq, 0);
        check64(msiReady == 1, "R1 msiReady", msiReady, 1);
        regCheck(3'd0, 32'h0, "R1 ctrl");
        regCheck(3'd5, 32'h0, "R1 rdOff");
        regCheck(3'd6, 32'h0, "R1 wrOff");
        regCheck(3'd3, 32'h0, "R1 baseHi");
        // R7 disabled: discarded
        sendMsi(32'h00AB);
        repeat (4) @(negedge clk);
        check64(memReq == 0, "R7 no request", memReq, 0);
        regCheck(3'd6, 32'h0, "R7 wrOff unchanged");
        // R2 map, read-only write offset, unused addresses
        regWrite(3'd3, 32'h0000_0001);
        regWrite(3'd4, 32'h8000_0000);
        regWrite(3'd6, 32'h0000_0120);
        regWrite(3'd2, 32'hFFFF_FFFF);
        regCheck(3'd6, 32'h0, "R2 wrOff read-only");
        regCheck(3'd2, 32'h0, "R2 unused addr");
        regCheck(3'd4, 32'h8000_0000, "R2 baseLo");
        regWrite(3'd0, 32'h0000_0009);
        regCheck(3'd0, 32'h0000_0009, "R2 ctrl bits");
        // R4 first record
        ackStall = 1'b1;
        sendMsi(32'h0001_2345);
        @(negedge clk);
        check64(memReq == 1, "R4 request up", memReq, 1);
        check64(memAddr == 64'h1_8000_0000, "R4 address", memAddr, 64'h1_8000_0000);
        check64(memData == 128'h2345, "R4 record data", memData, 128'h2345);
        repeat (6) @(negedge clk);
        check64(memReq == 1, "R5 held while unacked", memReq, 1);
        regCheck(3'd6, 32'h0, "R5 no advance before ack");
        ackStall = 1'b0;
        drain();
        regCheck(3'd6, 32'h10, "R5 advance after ack");
        check64(irqOut == 1, "R10 pending irq", irqOut, 1);
        sendMsi(32'h0000_BEEF);
        sendMsi(32'h0000_0077);
        drain();
        regCheck(3'd6, 32'h30, "R5 three records");
        regWrite(3'd5, 32'h0000_0030);
        @(negedge clk);
        check64(irqOut == 0, "R10 empty ring", irqOut, 0);
        // R6 masked read offset
        regWrite(3'd5, 32'h0001_2345);
        regCheck(3'd5, 32'h0000_2340, "R6 rd masked");
        regWrite(3'd0, 32'h0000_0001);
        @(negedge clk);
        check64(irqOut == 0, "R10 irq disabled", irqOut, 0);
        // R8 stop-on-full
        regWrite(3'd5, 32'h0000_0040);
        regWrite(3'd0, 32'h0000_001B);
        sendMsi(32'h0000_1111);
        repeat (3) @(negedge clk);
        regCheck(3'd6, 32'h30, "R8 dropped when full");
        regCheck(3'd0, 32'h0001_001B, "R8 sticky set");
        regWrite(3'd0, 32'h0001_001B);
        regCheck(3'd0, 32'h0000_001B, "R8 sticky cleared");
        // R9 overwrite
        regWrite(3'd0, 32'h0000_000B);
        sendMsi(32'h0000_2222);
        drain();
        regCheck(3'd6, 32'h40, "R9 wr after overwrite");
        regCheck(3'd5, 32'h50, "R9 rd pushed");
        // R5 wrap
        regWrite(3'd5, 32'h0);
        for (int i = 0; i < 2043; i++) sendMsi(32'(i));
        drain();
        regCheck(3'd6, 32'h7FF0, "R5 top slot");
        regCheck(3'd5, 32'h0, "R9 rd kept before full");
        sendMsi(32'h0000_3333);
        drain();
        regCheck(3'd6, 32'h0, "R5 wrap to zero");
        regCheck(3'd5, 32'h10, "R9 rd pushed at wrap");
        // R3 size codes
        regWrite(3'd0, 32'h0000_010B);
        regWrite(3'd5, 32'h0003_FFFF);
        regCheck(3'd5, 32'h0000_FFF0, "R3 code1 mask");
        regWrite(3'd0, 32'h0000_020B);
        regWrite(3'd5, 32'h0003_FFFF);
        regCheck(3'd5, 32'h0001_FFF0, "R3 code2 mask");
        regWrite(3'd0, 32'h0000_030B);
        regWrite(3'd5, 32'h0003_FFFF);
        regCheck(3'd5, 32'h0003_FFF0, "R3 code3 mask");
        // R7 disable again
        regWrite(3'd0, 32'h0000_0308);
        @(negedge clk);
        check64(irqOut == 0, "R10 off when disabled", irqOut, 0);
        sendMsi(32'h0000_4444);
        repeat (3) @(negedge clk);
        regCheck(3'd6, 32'h0, "R7 wr unchanged");
        repeat (4) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule